// File: doc/BRIEF.md
# Serial Port Receive Controller with Framing Check and Address Filtering

This block is the receive half of a classic asynchronous serial port. It watches a serial input line, oversamples it with a baud-rate tick supplied from outside, rebuilds frames of one start bit, eight data bits sent least significant bit first, an optional ninth bit and one stop bit, and loads the accepted byte into a receive buffer. When a frame is accepted it raises a receive-done flag. Software clears that flag before the next frame can be taken.

Two additions sit on top of the plain receiver. The first is a sticky framing-error flag. It is raised whenever a stop bit arrives low. It can be read and written through a register bit position that it shares with the upper mode bit, and a separate access-select input chooses which of the two that position reaches. The second is hardware address filtering for multidrop links. With filtering on in a nine-bit mode, the block only takes address frames (ninth bit set) whose byte matches either the node's masked own address or its derived broadcast address. Other traffic is dropped without disturbing software.

Top module: `serrx_ctrl`

## Requirements
- R1: After reset, rx_data = 0, rx_ninth = 0, rx_done = 0, frame_err = 0, and the internal upper mode bit is 0, so shared_rd reads 0.
- R2: Each bit lasts 16 baud ticks. A frame starts on a high-to-low transition of the synchronised line, seen from one tick to the next. Each bit's value is the 2-of-3 majority of samples 7, 8 and 9 counted from the start tick. If the start bit votes high, the frame is abandoned and nothing is loaded.
- R3: The mode is {mode_hi, mode_lo}. 01 selects eight data bits. 10 and 11 select eight data bits plus a ninth bit. 00 keeps the receiver idle. Data bits arrive least significant bit first.
- R4: In the nine-bit modes the ninth received bit is loaded into rx_ninth on acceptance. In the eight-bit mode rx_ninth keeps its value.
- R5: A stop bit that votes 0 sets frame_err. Later frames with good stop bits leave it set. Only a write through the shared bit clears it.
- R6: When shared_wr is pulsed with fe_access = 1, shared_wdata is written to frame_err. With fe_access = 0 it is written to mode_hi. shared_rd shows frame_err when fe_access = 1 and mode_hi when fe_access = 0.
- R7: With fe_access = 0, acceptance (rx_done rising) happens at the vote of the last data bit, which is the eighth bit in the eight-bit mode and the ninth bit otherwise. With fe_access = 1 it happens at the stop-bit vote.
- R8: While rx_enable = 0 no frame is accepted and rx_done does not rise.
- R9: If rx_done is still 1 when a frame completes, that frame is dropped and rx_data and rx_ninth keep their values.
- R10: In a nine-bit mode with multi_en = 1, a frame is accepted only if its ninth bit is 1 and its byte matches the own or broadcast address. In the eight-bit mode multi_en has no effect.
- R11: The own address matches when every byte bit whose node_mask bit is 1 equals the node_addr bit. Bits with mask 0 are don't care, so node_mask = 0 matches every byte.
- R12: The broadcast address is node_addr OR node_mask. A byte matches it when it has a 1 in every position where that OR is 1.
- R13: A done_clr pulse clears rx_done on the next clock unless a frame is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| mode_lo | input | 1 | Lower mode bit |
| multi_en | input | 1 | Address-filtering enable for nine-bit modes |
| rx_enable | input | 1 | Receive enable |
| fe_access | input | 1 | Shared bit reaches frame_err (1) or mode_hi (0) |
| node_addr | input | 8 | Own address |
| node_mask | input | 8 | Address mask, 0 bits are don't care |
| shared_wr | input | 1 | Write strobe for the shared bit |
| shared_wdata | input | 1 | Value written to the shared bit |
| done_clr | input | 1 | Software clear of rx_done |
| rx_data | output | 8 | Receive buffer |
| rx_ninth | output | 1 | Received ninth bit |
| rx_done | output | 1 | Receive-done flag |
| frame_err | output | 1 | Sticky framing-error flag |
| shared_rd | output | 1 | Read view of the shared bit |

## Verification
The bench sends a frame with a bad stop bit and then a clean one. A design that clears the error flag on a good stop bit loses the error, and one that decodes the shared bit wrongly reads back the mode bit in place of the flag. It measures rx_done part-way through the last data bit with both error-access settings. A receiver that accepts at the wrong bit shows the flag early or late. In the address tests it uses a byte that matches only the broadcast form, a byte that matches neither form, a matching byte with the ninth bit clear, and an all-zero mask. A filter that confuses the two address forms, or ignores the ninth bit, accepts or drops the wrong frame. Other stimuli check that frames are dropped while the done flag is still set, that a one-tick glitch inside a bit and a short false start are both rejected, and that the idle mode ignores traffic.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    // Two-of-three majority used for every bit decision
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/serrx_frame.sv
module serrx_frame
    import serrx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              rx_enable,
    input  logic              enable,
    input  logic              nine_mode,
    output logic              last_evt,
    output logic              stop_evt,
    output logic              stop_val,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_ninth,
    output logic              frm_nine
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;
    localparam int IW  = $clog2(DATA_W + 3);
    localparam logic [CW-1:0] SMP_A    = CW'(MID - 1);
    localparam logic [CW-1:0] SMP_B    = CW'(MID);
    localparam logic [CW-1:0] SMP_C    = CW'(MID + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [IW-1:0] IDX_LASTD = IW'(DATA_W);
    localparam logic [IW-1:0] IDX_NINTH = IW'(DATA_W + 1);
    localparam logic [IW-1:0] IDX_ONE   = IW'(1);

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic              s_a;
        logic              s_b;
        logic [DATA_W-1:0] dat;
        logic              ninth;
        logic              nine;
        logic              prev;
    } frame_t;

    frame_t fr_d, fr_q;
    logic   v;

    always_comb begin
        fr_d     = fr_q;
        last_evt = 1'b0;
        stop_evt = 1'b0;
        stop_val = 1'b1;
        v        = vote3(fr_q.s_a, fr_q.s_b, rx);
        if (tick) begin
            fr_d.prev = rx;
            if (fr_q.st == RX_IDLE) begin
                if (enable && rx_enable && fr_q.prev && !rx) begin
                    fr_d.st   = RX_BUSY;
                    fr_d.cnt  = CNT_ONE;
                    fr_d.idx  = '0;
                    fr_d.nine = nine_mode;
                end
            end else begin
                if (fr_q.cnt == SMP_A) fr_d.s_a = rx;
                if (fr_q.cnt == SMP_B) fr_d.s_b = rx;
                if (fr_q.cnt == SMP_C) begin
                    if (fr_q.idx == '0) begin
                        if (v) fr_d.st = RX_IDLE;          // false start
                    end else if (fr_q.idx <= IDX_LASTD) begin
                        for (int i = 0; i < DATA_W; i++) begin
                            if (fr_q.idx == IW'(i + 1)) fr_d.dat[i] = v;
                        end
                        if (fr_q.idx == IDX_LASTD && !fr_q.nine) last_evt = 1'b1;
                    end else if (fr_q.idx == IDX_NINTH && fr_q.nine) begin
                        fr_d.ninth = v;
                        last_evt   = 1'b1;
                    end else begin
                        stop_evt = 1'b1;
                        stop_val = v;
                        fr_d.st  = RX_IDLE;
                    end
                end
                if (fr_q.cnt == CNT_LAST) begin
                    fr_d.cnt = '0;
                    fr_d.idx = fr_q.idx + IDX_ONE;
                end else begin
                    fr_d.cnt = fr_q.cnt + CNT_ONE;
                end
            end
        end
        if (!rx_enable && fr_q.st == RX_BUSY) fr_d.st = RX_IDLE;
        frm_data  = fr_d.dat;
        frm_ninth = fr_d.ninth;
        frm_nine  = fr_q.nine;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q      <= '0;
            fr_q.st   <= RX_IDLE;
            fr_q.prev <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end
endmodule

// File: rtl/serrx_match.sv
module serrx_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] node_addr,
    input  logic [W-1:0] node_mask,
    output logic         addr_hit
);
    logic [W-1:0] own_ok, bc_ok, bc_need;

    assign bc_need = node_addr | node_mask;

    for (genvar g = 0; g < W; g++) begin : g_lane
        assign own_ok[g] = !node_mask[g] || (rx_byte[g] == node_addr[g]);
        assign bc_ok[g]  = !bc_need[g] || rx_byte[g];
    end

    assign addr_hit = (&own_ok) || (&bc_ok);
endmodule

// File: rtl/serrx_ctrl.sv
module serrx_ctrl #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic              mode_lo,
    input  logic              multi_en,
    input  logic              rx_enable,
    input  logic              fe_access,
    input  logic [DATA_W-1:0] node_addr,
    input  logic [DATA_W-1:0] node_mask,
    input  logic              shared_wr,
    input  logic              shared_wdata,
    input  logic              done_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ninth,
    output logic              rx_done,
    output logic              frame_err,
    output logic              shared_rd
);
    typedef struct packed {
        logic              mode_hi;
        logic              fe;
        logic              done;
        logic [DATA_W-1:0] data;
        logic              ninth;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              rx_s;
    logic              last_evt, stop_evt, stop_val;
    logic [DATA_W-1:0] frm_data;
    logic              frm_ninth, frm_nine;
    logic              addr_hit;
    logic              bad_stop, commit_evt, gate_ok, accept;

    serrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    serrx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .rx       (rx_s),
        .rx_enable(rx_enable),
        .enable   (ctl_q.mode_hi | mode_lo),
        .nine_mode(ctl_q.mode_hi),
        .last_evt (last_evt),
        .stop_evt (stop_evt),
        .stop_val (stop_val),
        .frm_data (frm_data),
        .frm_ninth(frm_ninth),
        .frm_nine (frm_nine)
    );

    serrx_match #(.W(DATA_W)) u_match (
        .rx_byte  (frm_data),
        .node_addr(node_addr),
        .node_mask(node_mask),
        .addr_hit (addr_hit)
    );

    always_comb begin
        ctl_d      = ctl_q;
        bad_stop   = stop_evt && !stop_val;
        commit_evt = fe_access ? stop_evt : last_evt;
        gate_ok    = !frm_nine || !multi_en || (frm_ninth && addr_hit);
        accept     = commit_evt && rx_enable && !ctl_q.done && gate_ok;

        if (shared_wr) begin
            if (fe_access) ctl_d.fe      = shared_wdata;
            else           ctl_d.mode_hi = shared_wdata;
        end
        if (bad_stop) ctl_d.fe = 1'b1;
        if (done_clr) ctl_d.done = 1'b0;
        if (accept) begin
            ctl_d.done = 1'b1;
            ctl_d.data = frm_data;
            if (frm_nine) ctl_d.ninth = frm_ninth;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rx_data   = ctl_q.data;
    assign rx_ninth  = ctl_q.ninth;
    assign rx_done   = ctl_q.done;
    assign frame_err = ctl_q.fe;
    assign shared_rd = fe_access ? ctl_q.fe : ctl_q.mode_hi;
endmodule

// File: rtl/serrx_ctrl_chk.sv
module serrx_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic              done_clr,
    input logic              fe_access,
    input logic              shared_wr,
    input logic              multi_en,
    input logic              rx_done,
    input logic              frame_err,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ninth,
    input logic              bad_stop,
    input logic              accept,
    input logic              frm_nine
);
    // R5: error flag survives unless software writes it
    a_r5_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !(shared_wr && fe_access)) |=> frame_err);

    // R5: a low stop bit raises the flag
    a_r5_fe_set: assert property (@(posedge clk) disable iff (!rst_n)
        bad_stop |=> frame_err);

    // R6: a mode-bit write leaves the error flag alone
    a_r6_mode_wr_keeps_fe: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_wr && !fe_access && !bad_stop) |=> (frame_err == $past(frame_err)));

    // R8: disabled receiver never raises done
    a_r8_no_accept_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !rx_done) |=> !rx_done);

    // R9: pending done freezes the buffer
    a_r9_hold_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !done_clr) |=> (rx_done && $stable(rx_data) && $stable(rx_ninth)));

    // R13: clear takes effect next cycle
    a_r13_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !accept) |=> !rx_done);

    // R10: filtered nine-bit acceptance needs a set ninth bit
    a_r10_ninth_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_done) && $past(frm_nine) && $past(multi_en)) |-> rx_ninth);
endmodule

bind serrx_ctrl serrx_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_enable(rx_enable),
    .done_clr (done_clr),
    .fe_access(fe_access),
    .shared_wr(shared_wr),
    .multi_en (multi_en),
    .rx_done  (rx_done),
    .frame_err(frame_err),
    .rx_data  (rx_data),
    .rx_ninth (rx_ninth),
    .bad_stop (bad_stop),
    .accept   (accept),
    .frm_nine (frm_nine)
);

// File: tb/serrx_ctrl_bench.sv
module serrx_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       baud_tick;
    logic       mode_lo = 1'b1;
    logic       multi_en = 1'b0;
    logic       rx_enable = 1'b1;
    logic       fe_access = 1'b0;
    logic [7:0] node_addr = 8'h00;
    logic [7:0] node_mask = 8'h00;
    logic       shared_wr = 1'b0;
    logic       shared_wdata = 1'b0;
    logic       done_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ninth;
    logic       rx_done;
    logic       frame_err;
    logic       shared_rd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_run = 1'b0;
    int tcnt = 0;

    typedef struct {
        logic [7:0] data;
        logic       ninth;
        bit         chk_ninth;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) tcnt <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
    assign baud_tick = (tcnt == 0);

    serrx_ctrl u_serrx_ctrl (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
        .mode_lo(mode_lo), .multi_en(multi_en), .rx_enable(rx_enable),
        .fe_access(fe_access), .node_addr(node_addr), .node_mask(node_mask),
        .shared_wr(shared_wr), .shared_wdata(shared_wdata), .done_clr(done_clr),
        .rx_data(rx_data), .rx_ninth(rx_ninth), .rx_done(rx_done),
        .frame_err(frame_err), .shared_rd(shared_rd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every rising done flag must match the head of the scoreboard
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && rx_done && !done_prev) begin
            if (sb.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL unexpected acceptance: actual data %0h expected no frame", rx_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " data"}, 32'(rx_data), 32'(e.data));
                if (e.chk_ninth) check({e.req, " ninth"}, 32'(rx_ninth), 32'(e.ninth));
            end
        end
        done_prev <= rx_done;
    end

    task automatic expect_frame(input logic [7:0] d, input logic n9, input bit c9, input string req);
        exp_t e;
        e.data = d; e.ninth = n9; e.chk_ninth = c9; e.req = req;
        sb.push_back(e);
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!baud_tick) @(posedge clk);
        end
    endtask

    task automatic drive_bit(input logic v, input bit glitch, input bit last, output logic mid);
        mid = 1'b0;
        @(negedge clk) rxd = v;
        if (glitch) begin
            wait_ticks(7);
            @(negedge clk) rxd = ~v;
            wait_ticks(1);
            @(negedge clk) rxd = v;
            wait_ticks(8);
        end else if (last) begin
            wait_ticks(12);
            @(negedge clk) mid = rx_done;
            wait_ticks(4);
        end else begin
            wait_ticks(16);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input bit nine, input logic n9,
                              input logic stopv, input logic [7:0] gl, output logic mid);
        logic m;
        int nb;
        nb = nine ? 9 : 8;
        mid = 1'b0;
        drive_bit(1'b0, 1'b0, 1'b0, m);
        for (int k = 0; k < nb; k++) begin
            drive_bit((k < 8) ? d[k] : n9, (k < 8) ? gl[k] : 1'b0, k == nb - 1, m);
            if (k == nb - 1) mid = m;
        end
        drive_bit(stopv, 1'b0, 1'b0, m);
        @(negedge clk) rxd = 1'b1;
        wait_ticks(6);
    endtask

    task automatic clear_done();
        @(negedge clk) done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_shared(input logic sel, input logic v);
        @(negedge clk) begin fe_access = sel; shared_wr = 1'b1; shared_wdata = v; end
        @(negedge clk) shared_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic mid;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 data",  32'(rx_data), 0);
        check("R1 ninth", 32'(rx_ninth), 0);
        check("R1 done",  32'(rx_done), 0);
        check("R1 err",   32'(frame_err), 0);
        check("R1 shared", 32'(shared_rd), 0);

        // R3 eight-bit mode, LSB first; R7 early acceptance with fe_access=0
        expect_frame(8'hA5, 1'b0, 1'b0, "R3");
        send_frame(8'hA5, 1'b0, 1'b0, 1'b1, 8'h00, mid);
        check("R7 early done", 32'(mid), 1);
        check("R4 ninth kept in 8-bit", 32'(rx_ninth), 0);

        // R9 drop while done still set
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1, 8'h00, mid);
        check("R9 data kept", 32'(rx_data), 32'h A5);
        check("R9 done", 32'(rx_done), 1);
        clear_done();
        check("R13 cleared", 32'(rx_done), 0);

        // R8 receiver disabled
        rx_enable = 1'b0;
        send_frame(8'h11, 1'b0, 1'b0, 1'b1, 8'h00, mid);
        check("R8 no done", 32'(rx_done), 0);
        check("R8 data kept", 32'(rx_data), 32'h A5);
        rx_enable = 1'b1;

        // R5 bad stop bit; R6 shared view
        expect_frame(8'h5A, 1'b0, 1'b0, "R5");
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 8'h00, mid);
        check("R5 err set", 32'(frame_err), 1);
        check("R6 view mode bit", 32'(shared_rd), 0);
        @(negedge clk) fe_access = 1'b1;
        @(negedge clk);
        check("R6 view err", 32'(shared_rd), 1);
        clear_done();

        // R7 late acceptance with fe_access=1; R5 sticky
        expect_frame(8'h77, 1'b0, 1'b0, "R7");
        send_frame(8'h77, 1'b0, 1'b0, 1'b1, 8'h00, mid);
        check("R7 no early done", 32'(mid), 0);
        check("R7 done at stop", 32'(rx_done), 1);
        check("R5 err sticky", 32'(frame_err), 1);
        clear_done();

        // R2 one-tick glitch in every data bit is voted out
        expect_frame(8'hC3, 1'b0, 1'b0, "R2 glitch");
        send_frame(8'hC3, 1'b0, 1'b0, 1'b1, 8'hFF, mid);
        clear_done();

        // R6 clear error via shared bit, mode bit untouched
        write_shared(1'b1, 1'b0);
        check("R6 err cleared", 32'(frame_err), 0);
        @(negedge clk) fe_access = 1'b0;
        @(negedge clk);
        check("R6 mode bit kept", 32'(shared_rd), 0);
        write_shared(1'b0, 1'b1);
        check("R6 mode bit written", 32'(shared_rd), 1);
        check("R6 err untouched", 32'(frame_err), 0);

        // R4 nine-bit mode (mode 11), filter off
        expect_frame(8'h42, 1'b1, 1'b1, "R4");
        send_frame(8'h42, 1'b1, 1'b1, 1'b1, 8'h00, mid);
        clear_done();
        expect_frame(8'h43, 1'b0, 1'b1, "R4");
        send_frame(8'h43, 1'b1, 1'b0, 1'b1, 8'h00, mid);
        clear_done();

        // R10 R11 R12 address filter: own F1 mask FA, broadcast FB
        multi_en = 1'b1; node_addr = 8'hF1; node_mask = 8'hFA;
        expect_frame(8'hF0, 1'b1, 1'b1, "R11 own");
        send_frame(8'hF0, 1'b1, 1'b1, 1'b1, 8'h00, mid);
        clear_done();
        send_frame(8'hF3, 1'b1, 1'b1, 1'b1, 8'h00, mid);
        check("R11 mismatch dropped", 32'(rx_done), 0);
        check("R11 data kept", 32'(rx_data), 32'h F0);
        expect_frame(8'hFF, 1'b1, 1'b1, "R12 broadcast");
        send_frame(8'hFF, 1'b1, 1'b1, 1'b1, 8'h00, mid);
        clear_done();
        send_frame(8'hF0, 1'b1, 1'b0, 1'b1, 8'h00, mid);
        check("R10 ninth clear dropped", 32'(rx_done), 0);
        check("R10 data kept", 32'(rx_data), 32'h FF);
        check("R10 ninth kept", 32'(rx_ninth), 1);
        node_mask = 8'h00;
        expect_frame(8'h00, 1'b1, 1'b1, "R11 zero mask");
        send_frame(8'h00, 1'b1, 1'b1, 1'b1, 8'h00, mid);
        clear_done();

        // R10 filter ignored in eight-bit mode; R4 ninth kept
        write_shared(1'b0, 1'b0);
        expect_frame(8'h13, 1'b0, 1'b0, "R10 8-bit");
        send_frame(8'h13, 1'b0, 1'b0, 1'b1, 8'h00, mid);
        check("R4 ninth kept", 32'(rx_ninth), 1);
        clear_done();

        // R2 false start
        @(negedge clk) rxd = 1'b0;
        wait_ticks(3);
        @(negedge clk) rxd = 1'b1;
        wait_ticks(30);
        check("R2 false start", 32'(rx_done), 0);
        expect_frame(8'h96, 1'b0, 1'b0, "R2 after false start");
        send_frame(8'h96, 1'b0, 1'b0, 1'b1, 8'h00, mid);
        clear_done();

        // R3 mode 00 keeps receiver idle
        mode_lo = 1'b0;
        send_frame(8'h55, 1'b0, 1'b0, 1'b1, 8'h00, mid);
        check("R3 idle mode", 32'(rx_done), 0);
        check("R3 idle data", 32'(rx_data), 32'h 96);
        mode_lo = 1'b1;

        check("scoreboard drained", 32'(sb.size()), 0);
        done_run = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule